// File: doc/BRIEF.md
# Two-Phase Bus Request Classifier

This block sits on the request phase of a shared system bus and names each new transaction. The request code is spread over two consecutive clocks. In the cycle where the address strobe is seen asserted, the block stores the first 6-bit request word. On the next clock it takes the second 6-bit word. It then reports the transaction kind and the fields packed into the two words.

All bus pins are active-low. The block inverts the strobe, the request lines and the parity line on entry, so every encoding below is a logical value in which asserted reads as 1. The request parity line is checked against each of the two words on its own cycle. A strobe that arrives while the second word is still awaited is refused and flagged.

The result is registered. It appears, together with a one-cycle valid pulse, in the clock after the second word. Address and data phases, snooping, deferral and arbitration belong to other blocks.

Top module: `bus_req_classifier`

## Requirements
- R1: A strobe seen asserted while no second word is pending captures the first word (A). The next clock captures the second word (B). txn_vld is 1 for exactly one cycle, in the cycle after word B was on the bus.
- R2: Kind codes for non-memory words, used only when A[2] and A[1] are both 0: A=000000 gives 0 (deferred reply) if B[5]=0; A=001000 gives 1 (interrupt acknowledge) for B[2:0]=000 and 2 (special) for B[2:0]=001; A=001001 gives 3 (interrupt) for B[2:0]=100 and 4 (translation-cache purge) for B[2:0]=101.
- R3: A=010000 gives 5 (I/O read) and A=010001 gives 6 (I/O write). Every other encoding gives kind 15 (reserved) with txn_rsvd=1. This includes A=000001, A=01100x, A=000000 with B[5]=1, and the leftover B patterns of A=001000 and A=001001. txn_rsvd is 0 for every other kind.
- R4: When A[2] or A[1] is 1, the word is a memory request, keyed by {A[5],A[2],A[1],A[0]}: 0010 gives 7 (read and invalidate), 01x0 gives 8 (read), 1100 gives 9 (read current) and 01x1 gives 10 (write).
- R5: Memory key 11x1 gives 11 (line replacement) only when B[2:0]=000, and 15 otherwise. All other memory keys give 15.
- R6: On the valid cycle, txn_asz=A[4:3], txn_dsz=B[4:3] and txn_len=B[2:0].
- R7: txn_snoop equals A[1] for kinds 10 and 11, and is 0 otherwise. txn_dc equals A[1] for kind 8, and is 0 otherwise.
- R8: Parity is even over the logical strobe, the 6 request bits and the parity bit, and is checked on the cycle of word A and on the cycle of word B. txn_perr is 1 on the valid cycle if either check failed.
- R9: A strobe asserted in the cycle of word B is ignored and does not start a new capture. txn_proto is 1 on that transaction's valid cycle.
- R10: While rst_n is 0, every output is 0 and no strobe is captured.
- R11: Outside the valid cycle, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strb_n | input | 1 | Address strobe pin, active low |
| rq_n | input | 6 | Request code pins, active low |
| rqpar_n | input | 1 | Request parity pin, active low |
| txn_vld | output | 1 | One-cycle result pulse |
| txn_kind | output | 4 | Transaction kind code (R2 to R5) |
| txn_asz | output | 2 | Address size field |
| txn_dsz | output | 2 | Data size field |
| txn_len | output | 3 | Length field |
| txn_snoop | output | 1 | Write snoop qualifier |
| txn_dc | output | 1 | Data/code qualifier of reads |
| txn_rsvd | output | 1 | Reserved encoding seen |
| txn_perr | output | 1 | Parity mismatch on either word |
| txn_proto | output | 1 | Strobe arrived while word B was pending |

## Verification
Word A is swept through all 64 values, each paired with a set of B words. The B set holds the low-bit patterns that split the special and interrupt groups, B[5] set and clear for the deferred-reply case, and zero and non-zero lengths that decide line replacement against reserved. Gaps of zero and one cycle are mixed in, so back-to-back requests are told apart from isolated ones. Separate runs spoil the parity of word A only, word B only and both words, which shows that each word has its own check. Further runs assert the strobe during word B, and random traffic tests the decode mixed with these faults.

// File: rtl/bq_pkg.sv
package bq_pkg;
  localparam int REQ_W = 6;
  localparam int ASZ_W = 2;
  localparam int DSZ_W = 2;
  localparam int LEN_W = 3;
  localparam int KIND_W = 4;

  typedef enum logic [KIND_W-1:0] {
    BQ_DEFER    = 4'd0,
    BQ_INTA     = 4'd1,
    BQ_SPECIAL  = 4'd2,
    BQ_INTR     = 4'd3,
    BQ_PURGE    = 4'd4,
    BQ_IORD     = 4'd5,
    BQ_IOWR     = 4'd6,
    BQ_MRDINV   = 4'd7,
    BQ_MRD      = 4'd8,
    BQ_MRDCUR   = 4'd9,
    BQ_MWR      = 4'd10,
    BQ_LINEREPL = 4'd11,
    BQ_RSVD     = 4'd15
  } bq_kind_e;

  typedef struct packed {
    bq_kind_e         kind;
    logic [ASZ_W-1:0] asz;
    logic [DSZ_W-1:0] dsz;
    logic [LEN_W-1:0] len;
    logic             snp;
    logic             dc;
  } bq_info_t;

  // 1 when even parity over strobe, request bits and parity bit is broken
  function automatic logic par_bad(input logic stb, input logic [REQ_W-1:0] rq,
                                   input logic par);
    return stb ^ (^rq) ^ par;
  endfunction

  // non-memory group: a[2] and a[1] both clear
  function automatic bq_kind_e kind_plain(input logic [REQ_W-1:0] a,
                                          input logic [REQ_W-1:0] b);
    bq_kind_e k;
    k = BQ_RSVD;
    unique case (a)
      6'b000000: k = b[5] ? BQ_RSVD : BQ_DEFER;
      6'b001000: begin
        if (b[2:0] == 3'b000) k = BQ_INTA;
        else if (b[2:0] == 3'b001) k = BQ_SPECIAL;
      end
      6'b001001: begin
        if (b[2:0] == 3'b100) k = BQ_INTR;
        else if (b[2:0] == 3'b101) k = BQ_PURGE;
      end
      6'b010000: k = BQ_IORD;
      6'b010001: k = BQ_IOWR;
      default:   k = BQ_RSVD;
    endcase
    return k;
  endfunction

  // memory group: keyed by {a5,a2,a1,a0}
  function automatic bq_kind_e kind_mem(input logic [REQ_W-1:0] a,
                                        input logic [REQ_W-1:0] b);
    logic [3:0] key;
    bq_kind_e   k;
    key = {a[5], a[2], a[1], a[0]};
    casez (key)
      4'b0010: k = BQ_MRDINV;
      4'b01?0: k = BQ_MRD;
      4'b1100: k = BQ_MRDCUR;
      4'b01?1: k = BQ_MWR;
      4'b11?1: k = (b[2:0] == 3'b000) ? BQ_LINEREPL : BQ_RSVD;
      default: k = BQ_RSVD;
    endcase
    return k;
  endfunction

  function automatic bq_info_t classify(input logic [REQ_W-1:0] a,
                                        input logic [REQ_W-1:0] b);
    bq_info_t r;
    r.kind = (a[2] | a[1]) ? kind_mem(a, b) : kind_plain(a, b);
    r.asz  = a[4:3];
    r.dsz  = b[4:3];
    r.len  = b[2:0];
    r.snp  = ((r.kind == BQ_MWR) || (r.kind == BQ_LINEREPL)) ? a[1] : 1'b0;
    r.dc   = (r.kind == BQ_MRD) ? a[1] : 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/bq_capture.sv
module bq_capture
  import bq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic [REQ_W-1:0] rq,
  input  logic             par,
  output logic             acc_a,
  output logic             fin_b,
  output logic             clash,
  output logic [REQ_W-1:0] word_a,
  output logic [REQ_W-1:0] word_b,
  output logic             perr_a,
  output logic             perr_b
);
  logic             pend_q;
  logic [REQ_W-1:0] wa_q;
  logic             pa_q;
  logic             perr_now;

  assign perr_now = par_bad(stb, rq, par);
  assign acc_a    = stb & ~pend_q;
  assign fin_b    = pend_q;
  assign clash    = pend_q & stb;
  assign word_a   = wa_q;
  assign word_b   = rq;
  assign perr_a   = pa_q;
  assign perr_b   = perr_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wa_q   <= '0;
      pa_q   <= 1'b0;
    end else if (acc_a) begin
      pend_q <= 1'b1;
      wa_q   <= rq;
      pa_q   <= perr_now;
    end else if (fin_b) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bq_decode.sv
module bq_decode
  import bq_pkg::*;
(
  input  logic [REQ_W-1:0] word_a,
  input  logic [REQ_W-1:0] word_b,
  output bq_info_t         info
);
  always_comb info = classify(word_a, word_b);
endmodule

// File: rtl/bq_outreg.sv
module bq_outreg
  import bq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fin_b,
  input  bq_info_t info,
  input  logic     perr,
  input  logic     clash,
  output logic     vld,
  output bq_info_t info_q,
  output logic     rsvd,
  output logic     perr_q,
  output logic     proto
);
  always_ff @(posedge clk) begin
    if (!rst_n || !fin_b) begin
      vld    <= 1'b0;
      info_q <= '0;
      rsvd   <= 1'b0;
      perr_q <= 1'b0;
      proto  <= 1'b0;
    end else begin
      vld    <= 1'b1;
      info_q <= info;
      rsvd   <= (info.kind == BQ_RSVD);
      perr_q <= perr;
      proto  <= clash;
    end
  end
endmodule

// File: rtl/bus_req_classifier.sv
module bus_req_classifier
  import bq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strb_n,
  input  logic [REQ_W-1:0] rq_n,
  input  logic             rqpar_n,
  output logic             txn_vld,
  output logic [KIND_W-1:0] txn_kind,
  output logic [ASZ_W-1:0] txn_asz,
  output logic [DSZ_W-1:0] txn_dsz,
  output logic [LEN_W-1:0] txn_len,
  output logic             txn_snoop,
  output logic             txn_dc,
  output logic             txn_rsvd,
  output logic             txn_perr,
  output logic             txn_proto
);
  logic             stb, par;
  logic [REQ_W-1:0] rq;
  logic             acc_a, fin_b, clash;
  logic [REQ_W-1:0] word_a, word_b;
  logic             perr_a, perr_b;
  bq_info_t         info, info_q;

  assign stb = ~strb_n;
  assign rq  = ~rq_n;
  assign par = ~rqpar_n;

  bq_capture u_cap (
    .clk(clk), .rst_n(rst_n), .stb(stb), .rq(rq), .par(par),
    .acc_a(acc_a), .fin_b(fin_b), .clash(clash),
    .word_a(word_a), .word_b(word_b), .perr_a(perr_a), .perr_b(perr_b)
  );

  bq_decode u_dec (.word_a(word_a), .word_b(word_b), .info(info));

  bq_outreg u_out (
    .clk(clk), .rst_n(rst_n), .fin_b(fin_b), .info(info),
    .perr(perr_a | perr_b), .clash(clash),
    .vld(txn_vld), .info_q(info_q), .rsvd(txn_rsvd),
    .perr_q(txn_perr), .proto(txn_proto)
  );

  assign txn_kind  = info_q.kind;
  assign txn_asz   = info_q.asz;
  assign txn_dsz   = info_q.dsz;
  assign txn_len   = info_q.len;
  assign txn_snoop = info_q.snp;
  assign txn_dc    = info_q.dc;
endmodule

// File: rtl/bq_checker.sv
module bq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_a,
  input logic       fin_b,
  input logic       clash,
  input logic       txn_vld,
  input logic [3:0] txn_kind,
  input logic [2:0] txn_len,
  input logic       txn_snoop,
  input logic       txn_dc,
  input logic       txn_rsvd,
  input logic       txn_perr,
  input logic       txn_proto
);
  AST_ACCEPT_THEN_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    acc_a |=> fin_b); // R1
  AST_VALID_AFTER_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    fin_b |=> txn_vld); // R1
  AST_VALID_NEEDS_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    txn_vld |-> $past(fin_b)); // R1
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    txn_vld |=> !txn_vld); // R1
  AST_RSVD_MATCHES_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    txn_vld |-> (txn_rsvd == (txn_kind == 4'd15))); // R3
  AST_LINEREPL_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_vld && txn_kind == 4'd11) |-> (txn_len == 3'd0)); // R5
  AST_SNOOP_ON_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    txn_snoop |-> (txn_kind == 4'd10 || txn_kind == 4'd11)); // R7
  AST_DC_ON_READS: assert property (@(posedge clk) disable iff (!rst_n)
    txn_dc |-> (txn_kind == 4'd8)); // R7
  AST_CLASH_NOT_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> !acc_a); // R9
  AST_CLASH_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> (txn_proto && txn_vld)); // R9
  AST_QUIET_OFF_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_vld |-> (txn_kind == 4'd0 && !txn_rsvd && !txn_perr && !txn_proto
                  && !txn_snoop && !txn_dc && txn_len == 3'd0)); // R11
endmodule

bind bus_req_classifier bq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .acc_a(acc_a), .fin_b(fin_b), .clash(clash),
  .txn_vld(txn_vld), .txn_kind(txn_kind), .txn_len(txn_len),
  .txn_snoop(txn_snoop), .txn_dc(txn_dc), .txn_rsvd(txn_rsvd),
  .txn_perr(txn_perr), .txn_proto(txn_proto)
);

// File: tb/sim_bus_req_classifier.sv
module sim_bus_req_classifier;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strb_n = 1'b1;
  logic [5:0] rq_n = 6'h3f;
  logic       rqpar_n = 1'b1;
  logic       txn_vld;
  logic [3:0] txn_kind;
  logic [1:0] txn_asz, txn_dsz;
  logic [2:0] txn_len;
  logic       txn_snoop, txn_dc, txn_rsvd, txn_perr, txn_proto;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_req_classifier u0 (
    .clk(clk), .rst_n(rst_n), .strb_n(strb_n), .rq_n(rq_n), .rqpar_n(rqpar_n),
    .txn_vld(txn_vld), .txn_kind(txn_kind), .txn_asz(txn_asz),
    .txn_dsz(txn_dsz), .txn_len(txn_len), .txn_snoop(txn_snoop),
    .txn_dc(txn_dc), .txn_rsvd(txn_rsvd), .txn_perr(txn_perr),
    .txn_proto(txn_proto)
  );

  // ---------------- reference model ----------------
  function automatic int ref_kind(input bit [5:0] a, input bit [5:0] b);
    int lo;
    lo = int'(b[2:0]);
    if (a[2] || a[1]) begin
      if (a == {a[5], a[4:3], 3'b010} && !a[5]) return 7;
      if (!a[5] && a[2] && !a[0]) return 8;
      if (a[5] && a[2] && !a[1] && !a[0]) return 9;
      if (!a[5] && a[2] && a[0]) return 10;
      if (a[5] && a[2] && a[0]) return (lo == 0) ? 11 : 15;
      return 15;
    end
    if (a == 6'd0) return b[5] ? 15 : 0;
    if (a == 6'd8) return (lo == 0) ? 1 : (lo == 1) ? 2 : 15;
    if (a == 6'd9) return (lo == 4) ? 3 : (lo == 5) ? 4 : 15;
    if (a == 6'd16) return 5;
    if (a == 6'd17) return 6;
    return 15;
  endfunction

  bit       m_pend;
  bit [5:0] m_a;
  bit       m_aerr;
  int e_vld, e_kind, e_asz, e_dsz, e_len, e_snp, e_dc, e_rsvd, e_perr, e_proto;

  always @(posedge clk) begin
    bit s, p, bad;
    bit [5:0] r;
    s = ~strb_n; r = ~rq_n; p = ~rqpar_n;
    bad = (s + $countones(r) + p) % 2 == 1;
    e_vld = 0; e_kind = 0; e_asz = 0; e_dsz = 0; e_len = 0;
    e_snp = 0; e_dc = 0; e_rsvd = 0; e_perr = 0; e_proto = 0;
    if (!rst_n) begin
      m_pend = 0; m_a = 0; m_aerr = 0;
    end else if (m_pend) begin
      e_vld  = 1;
      e_kind = ref_kind(m_a, r);
      e_asz  = m_a[4:3];
      e_dsz  = r[4:3];
      e_len  = r[2:0];
      e_snp  = (e_kind == 10 || e_kind == 11) ? m_a[1] : 0;
      e_dc   = (e_kind == 8) ? m_a[1] : 0;
      e_rsvd = (e_kind == 15);
      e_perr = m_aerr || bad;
      e_proto = s;
      m_pend = 0;
    end else if (s) begin
      m_pend = 1; m_a = r; m_aerr = bad;
    end
  end

  task automatic chk(input int got, input int exp, input string tag, input string what);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic string kind_tag(input int k);
    if (k <= 4) return "R2";
    if (k == 5 || k == 6 || k == 15) return "R3";
    if (k == 11) return "R5";
    return "R4";
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk(txn_vld, 0, "R10", "vld in reset");
        chk({txn_kind, txn_rsvd, txn_perr, txn_proto}, 0, "R10", "outputs in reset");
      end else if (e_vld == 0) begin
        chk(txn_vld, 0, "R1", "vld");
        chk({txn_kind, txn_asz, txn_dsz, txn_len, txn_snoop, txn_dc,
             txn_rsvd, txn_perr, txn_proto}, 0, "R11", "idle outputs");
      end else begin
        chk(txn_vld, 1, "R1", "vld");
        chk(txn_kind, e_kind, kind_tag(e_kind), "kind");
        chk(txn_rsvd, e_rsvd, "R3", "rsvd flag");
        chk({txn_asz, txn_dsz, txn_len}, (e_asz << 5) | (e_dsz << 3) | e_len,
            "R6", "asz/dsz/len");
        chk({txn_snoop, txn_dc}, (e_snp << 1) | e_dc, "R7", "snoop/dc");
        chk(txn_perr, e_perr, "R8", "parity error");
        chk(txn_proto, e_proto, "R9", "protocol error");
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input bit s, input bit [5:0] r, input bit flip);
    @(posedge clk);
    #1;
    strb_n  = ~s;
    rq_n    = ~r;
    rqpar_n = ~((s ^ (^r)) ^ flip);
  endtask

  task automatic xact(input bit [5:0] a, input bit [5:0] b, input bit fa,
                      input bit fb, input int gap);
    drive(1'b1, a, fa);
    drive(1'b0, b, fb);
    for (int i = 0; i < gap; i++) drive(1'b0, 6'd0, 1'b0);
  endtask

  initial begin
    bit [5:0] blist [8];
    blist[0] = 6'h00; blist[1] = 6'h01; blist[2] = 6'h04; blist[3] = 6'h05;
    blist[4] = 6'h20; blist[5] = 6'h1f; blist[6] = 6'h0a; blist[7] = 6'h33;
    // R10: strobe held during reset must not be captured
    drive(1'b1, 6'h12, 1'b0);
    drive(1'b1, 6'h15, 1'b0);
    drive(1'b0, 6'h00, 1'b0);
    rst_n = 1'b1;
    drive(1'b0, 6'h00, 1'b0);
    drive(1'b0, 6'h00, 1'b0);
    // R2-R7 sweep of every first word
    for (int a = 0; a < 64; a++)
      for (int j = 0; j < 8; j++)
        xact(6'(a), blist[j], 1'b0, 1'b0, (a % 3 == 0) ? 0 : 1);
    // R8 parity faults per word
    xact(6'h14, 6'h08, 1'b1, 1'b0, 1);
    xact(6'h14, 6'h08, 1'b0, 1'b1, 1);
    xact(6'h2d, 6'h00, 1'b1, 1'b1, 0);
    xact(6'h10, 6'h00, 1'b0, 1'b0, 1);
    // R9 strobe during second word is ignored
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, 6'h08, 1'b0);
      drive(1'b1, 6'h3d, 1'b0);
      drive(1'b0, 6'h00, 1'b0);
      drive(1'b0, 6'h00, 1'b0);
    end
    drive(1'b1, 6'h2c, 1'b0);
    drive(1'b1, 6'h00, 1'b1);
    drive(1'b0, 6'h00, 1'b0);
    // mixed random traffic
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom % 16;
      if (r == 0) begin
        drive(1'b1, 6'($urandom), 1'b0);
        drive(1'b1, 6'($urandom), 1'($urandom));
      end else begin
        xact(6'($urandom), 6'($urandom), r == 1, r == 2, $urandom % 3);
      end
    end
    // R10 reset mid-transaction drops the pending word
    drive(1'b1, 6'h12, 1'b0);
    rst_n = 1'b0;
    drive(1'b0, 6'h00, 1'b0);
    rst_n = 1'b1;
    drive(1'b0, 6'h00, 1'b0);
    drive(1'b0, 6'h00, 1'b0);
    drive(1'b0, 6'h00, 1'b0);
    @(negedge clk);
    #1;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule